// File: doc/BRIEF.md
# Seven-Input Ones Counter from Full-Adder Cells

This block is a purely combinational parallel counter, sometimes called a 7:3 compressor. It takes a 7-bit vector and returns, as a 3-bit unsigned number, how many of its bits are set. Such counters appear inside the reduction trees that sum the partial products of a multiplier. Other uses include population counts, majority votes and parity.

No behavioural adder or lookup produces the count. It comes from exactly four instances of one full-adder cell. A full adder already counts the ones among its three inputs: its sum carries weight one and its carry weight two.

- Two cells reduce input bits 0..2 and 3..5.
- A third cell merges their two weight-one sums with the leftover bit 6. Its sum is the final bit 0.
- The three weight-two carries meet in a fourth cell. That cell's sum and carry are the final bits 1 and 2.

The block has no clock, no reset and no handshake.

Top module: `sevenbit_tally`

## Requirements
- R1: For every one of the 128 values of `vec_i`, `tally_o` equals the number of set bits in `vec_i`, read as an unsigned 3-bit binary number.
- R2: An input of all zeros gives `tally_o` = 3'b000.
- R3: An input of all ones (7'b1111111) gives `tally_o` = 3'b111, the largest count, with no wrap-around.
- R4: The inputs 7'b1100110 and 7'b1001110 both give `tally_o` = 3'b100.
- R5: The full-adder cell `tally_fa_cell` gives `{carry, sum}` equal to the number of ones among `a`, `b` and `cin`, for all eight input combinations. Here sum = a^b^cin and carry = majority(a, b, cin).
- R6: The result depends only on how many bits are set, not on where they are. Rotating `vec_i` by any amount leaves `tally_o` unchanged.
- R7: `tally_o[0]` equals the XOR (odd parity) of all seven input bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | 7 | Vector whose set bits are counted |
| tally_o | output | 3 | Unsigned number of set bits in `vec_i` |

## Verification
The bench drives all 128 input values, so a weight slip is exposed on the first vector that depends on it. Routing a carry into the weight-one cell, or dropping bit 6, would give counts that are off by one or two for many inputs. The all-ones input is the one value whose count needs every output bit set. A design that loses the final carry would return 3 there instead of 7. Rotations of a fixed pattern and the parity bit expose wiring that treats input positions unequally. Exercising the cell on its own pins a swapped sum and carry, or an OR in place of the majority, to the cell rather than the tree.

// File: rtl/tally_pkg.sv
package tally_pkg;

  localparam int unsigned VEC_W   = 7;
  localparam int unsigned CNT_W   = $clog2(VEC_W + 1);
  localparam int unsigned GROUP_W = 3;
  localparam int unsigned N_GROUP = 2;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  // One full adder: weight-one sum and weight-two carry.
  function automatic fa_out_t fa_eval(input logic a, input logic b, input logic c);
    fa_out_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (a & c) | (b & c);
    return r;
  endfunction

  // Plain ones count, used by the checker as an independent model.
  function automatic logic [CNT_W-1:0] ones_of(input logic [VEC_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < VEC_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/tally_fa_cell.sv
module tally_fa_cell
  import tally_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic carry
);

  fa_out_t r;

  always_comb r = fa_eval(a, b, cin);

  assign sum   = r.sum;
  assign carry = r.carry;

endmodule

// File: rtl/sevenbit_tally.sv
module sevenbit_tally
  import tally_pkg::*;
(
  input  logic [6:0] vec_i,
  output logic [2:0] tally_o
);

  // First level: two cells, each over one three-bit group of the input.
  logic [N_GROUP-1:0] grp_sum;
  logic [N_GROUP-1:0] grp_carry;

  for (genvar g = 0; g < N_GROUP; g++) begin : g_grp
    tally_fa_cell u_cell (
      .a     (vec_i[g*GROUP_W + 0]),
      .b     (vec_i[g*GROUP_W + 1]),
      .cin   (vec_i[g*GROUP_W + 2]),
      .sum   (grp_sum[g]),
      .carry (grp_carry[g])
    );
  end

  // Weight-one merge: both group sums plus the leftover input bit.
  logic mid_sum;
  logic mid_carry;

  tally_fa_cell u_weight1 (
    .a     (grp_sum[0]),
    .b     (grp_sum[1]),
    .cin   (vec_i[VEC_W-1]),
    .sum   (mid_sum),
    .carry (mid_carry)
  );

  // Weight-two merge: the three carries.
  logic hi_sum;
  logic hi_carry;

  tally_fa_cell u_weight2 (
    .a     (grp_carry[0]),
    .b     (grp_carry[1]),
    .cin   (mid_carry),
    .sum   (hi_sum),
    .carry (hi_carry)
  );

  assign tally_o = {hi_carry, hi_sum, mid_sum};

endmodule

// File: rtl/sevenbit_tally_checker.sv
module sevenbit_tally_checker
  import tally_pkg::*;
(
  input logic [6:0] vec_i,
  input logic [2:0] tally_o,
  input logic [1:0] grp_sum,
  input logic [1:0] grp_carry,
  input logic       mid_sum,
  input logic       mid_carry,
  input logic       hi_sum,
  input logic       hi_carry
);

  always_comb begin
    if (!$isunknown(vec_i)) begin
      // R1: output matches an independent loop count.
      a_r1_count_matches: assert (tally_o == ones_of(vec_i))
        else $error("a_r1_count_matches: vec=%b tally=%0d", vec_i, tally_o);
      // R7: the low bit carries the parity of the input.
      a_r7_parity: assert (tally_o[0] == ^vec_i)
        else $error("a_r7_parity: vec=%b", vec_i);
      // R5: each group cell counts the ones of its own input bits.
      a_r5_group0: assert ({grp_carry[0], grp_sum[0]} == 2'($countones(vec_i[2:0])))
        else $error("a_r5_group0");
      a_r5_group1: assert ({grp_carry[1], grp_sum[1]} == 2'($countones(vec_i[5:3])))
        else $error("a_r5_group1");
      // R5: weight-one merge counts its three inputs.
      a_r5_weight1: assert ({mid_carry, mid_sum} ==
                            2'(grp_sum[0]) + 2'(grp_sum[1]) + 2'(vec_i[6]))
        else $error("a_r5_weight1");
      // R5: weight-two merge counts the three carries.
      a_r5_weight2: assert ({hi_carry, hi_sum} ==
                            2'(grp_carry[0]) + 2'(grp_carry[1]) + 2'(mid_carry))
        else $error("a_r5_weight2");
      // R3: all ones reaches the top count.
      if (&vec_i) begin
        a_r3_no_overflow: assert (tally_o == 3'b111)
          else $error("a_r3_no_overflow");
      end
      // R2: empty input counts zero.
      if (vec_i == '0) begin
        a_r2_zero: assert (tally_o == 3'b000)
          else $error("a_r2_zero");
      end
    end
  end

endmodule

bind sevenbit_tally sevenbit_tally_checker u_chk (
  .vec_i     (vec_i),
  .tally_o   (tally_o),
  .grp_sum   (grp_sum),
  .grp_carry (grp_carry),
  .mid_sum   (mid_sum),
  .mid_carry (mid_carry),
  .hi_sum    (hi_sum),
  .hi_carry  (hi_carry)
);

// File: tb/sevenbit_tally_test.sv
module sevenbit_tally_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic [6:0] vec = '0;
  logic [2:0] tally;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [6:0] stim;
    logic [2:0] exp;
    string      req;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sevenbit_tally uut (.vec_i(vec), .tally_o(tally));

  // Stand-alone cell for R5.
  logic ca, cb, cc, cs, cco;
  tally_fa_cell cell_uut (.a(ca), .b(cb), .cin(cc), .sum(cs), .carry(cco));

  // Reference count written as a bit-clearing loop.
  function automatic logic [2:0] ref_count(input logic [6:0] v);
    logic [6:0] t = v;
    logic [2:0] n = 0;
    while (t != 0) begin
      t = t & (t - 7'd1);
      n = n + 3'd1;
    end
    return n;
  endfunction

  function automatic logic [6:0] rotl(input logic [6:0] v, input int k);
    logic [6:0] r = v;
    for (int i = 0; i < k; i++) r = {r[5:0], r[6]};
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v, input logic [2:0] e, input string req);
    item_t it;
    @(posedge clk);
    vec = v;
    it.stim = v; it.exp = e; it.req = req;
    sb.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.req, {29'd0, tally}, {29'd0, it.exp});
      if (it.req == "R1") check("R7", {31'd0, tally[0]}, {31'd0, ^it.stim});
    end
  end

  initial begin
    ca = 0; cb = 0; cc = 0;
    // Reset state: zero input, zero count (R2).
    drive(7'b0000000, 3'b000, "R2");
    drive(7'b1111111, 3'b111, "R3");
    drive(7'b1100110, 3'b100, "R4");
    drive(7'b1001110, 3'b100, "R4");
    // R1 and R7: every input value.
    for (int v = 0; v < 128; v++) drive(7'(v), ref_count(7'(v)), "R1");
    // R6: rotations of fixed patterns keep the count.
    for (int p = 0; p < 4; p++) begin
      logic [6:0] pat;
      pat = (p == 0) ? 7'b0000001 : (p == 1) ? 7'b0000011 :
            (p == 2) ? 7'b0101001 : 7'b1110110;
      for (int k = 0; k < 7; k++) drive(rotl(pat, k), ref_count(pat), "R6");
    end
    // R5: full-adder cell on its own.
    for (int c = 0; c < 8; c++) begin
      @(posedge clk);
      {ca, cb, cc} = 3'(c);
      @(negedge clk);
      check("R5", {30'd0, cco, cs}, 32'($countones(3'(c))));
    end
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule